// File: doc/BRIEF.md
# Windowed Stereo Correspondence Seeker

The block searches the slave sensor's intensity map for the pixel that corresponds to one active pixel of the master sensor's map, once per frame. A frame strobe restarts a frame timer. When half of the frame period has passed, the block walks the master map in address order. It stops at the first entry whose value reaches an activity threshold. That coordinate indexes an externally held table, computed offline, which returns the centre of the search window in the slave image.

The block then visits a fixed rectangle of ±`HALF_H` columns by ±`HALF_V` rows around that centre, in row-major order. Window positions outside the image are skipped without a read. The first slave pixel whose intensity lies within `TOL` of the master intensity is the match. The block reports the matched coordinates, or a no-match outcome, together with the number of cycles the search took. A frame strobe aborts any search in progress.

All three maps sit outside the block behind synchronous read ports. Each port returns data in the cycle after its address is presented. A map address is `{y, x}`, so address = y·W + x with W = 2^`COORD_W`.

Top module: `stereo_seeker`

## Requirements
- R1: While reset is asserted, `done_o` and `match_o` are 0 and `m_addr_o` is 0.
- R2: A search starts exactly FRAME_CYC/2 cycles after the clock edge that samples `frame_i` high. The first result therefore appears FRAME_CYC/2 + elapsed cycles after that edge. At most one search runs per frame.
- R3: The master pixel is the first address, counting upward from 0, whose master value is at least `THRESH`. If no address qualifies, no result is issued in that frame.
- R4: The master address is presented on `lut_addr_o`, and the returned (`lut_x_i`, `lut_y_i`) is the window centre.
- R5: Window positions are visited row by row, from dy = −HALF_V to +HALF_V, with dx running from −HALF_H to +HALF_H inside each row. The first accepted position is reported, and the search ends there.
- R6: A slave pixel is accepted when |slave − master| ≤ TOL, with both bounds inclusive.
- R7: A window position whose x or y falls outside 0..W−1 is skipped in one cycle and is never accepted.
- R8: A window with no accepted pixel, whether it is empty or holds only out-of-tolerance values, yields `done_o` with `match_o`=0 and coordinates 0.
- R9: `elapsed_o` equals the number of busy cycles of the search. That is 2 per master address read (including the selected one), plus 2 for the table, plus 2 per in-range window position visited, plus 1 per skipped position. It never exceeds 2·W² + 2 + 2·(2·HALF_H+1)·(2·HALF_V+1).
- R10: `frame_i` aborts a running search with no result. This holds even when the strobe falls on the edge at which the result would have been issued.
- R11: `done_o` is a single-cycle pulse, and `match_o` is high only together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | Frame restart strobe |
| m_addr_o | output | 2*COORD_W | Master map read address {y,x} |
| m_data_i | input | PIX_W | Master map data, one cycle after address |
| lut_addr_o | output | 2*COORD_W | Centre table read address (master coordinate) |
| lut_x_i | input | COORD_W | Window centre column |
| lut_y_i | input | COORD_W | Window centre row |
| s_addr_o | output | 2*COORD_W | Slave map read address {y,x} |
| s_data_i | input | PIX_W | Slave map data, one cycle after address |
| done_o | output | 1 | Result pulse |
| match_o | output | 1 | Match found (valid with done_o) |
| match_x_o | output | COORD_W | Matched slave column, 0 on no match |
| match_y_o | output | COORD_W | Matched slave row, 0 on no match |
| elapsed_o | output | ELW | Busy cycles of the reported search |

## Verification
The frame strobe and the result can meet on one edge. The strobe also marks the start of the next search. The bench computes the exact busy-cycle count of a search from its own model of the maps. It then raises the strobe so that it is sampled on the very edge where the result would register. Correct behaviour is that no `done_o` pulse appears at that point. A fresh search must then finish exactly half a frame plus the same busy count after that strobe edge.

// File: rtl/stereo_seek_pkg.sv
package stereo_seek_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MSCAN,
    ST_LUT,
    ST_WIN,
    ST_HOLD
  } seek_state_e;
endpackage

// File: rtl/stereo_seek_frame_timer.sv
module stereo_seek_frame_timer #(
  parameter int FRAME_CYC = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  output logic arm_o
);
  localparam int HALF = FRAME_CYC / 2;
  localparam int FW   = $clog2(HALF + 1);

  logic [FW-1:0] fcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    fcnt_q <= '0;
    else if (frame_i)               fcnt_q <= '0;
    else if (fcnt_q != FW'(HALF))   fcnt_q <= fcnt_q + 1'b1;
  end

  // saturating count: fires once per frame
  assign arm_o = (fcnt_q == FW'(HALF - 1)) && !frame_i;
endmodule

// File: rtl/stereo_seek_window.sv
module stereo_seek_window #(
  parameter int COORD_W = 7,
  parameter int HALF_H  = 3,
  parameter int HALF_V  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [COORD_W-1:0] ctr_x_i,
  input  logic [COORD_W-1:0] ctr_y_i,
  input  logic               step_i,
  output logic [COORD_W-1:0] x_o,
  output logic [COORD_W-1:0] y_o,
  output logic               in_range_o,
  output logic               last_o
);
  localparam int SW = COORD_W + 2;
  localparam logic signed [SW-1:0] DX_MAX = SW'(HALF_H);
  localparam logic signed [SW-1:0] DX_MIN = SW'(-HALF_H);
  localparam logic signed [SW-1:0] DY_MAX = SW'(HALF_V);
  localparam logic signed [SW-1:0] DY_MIN = SW'(-HALF_V);

  logic signed [SW-1:0] cx_q, cy_q, dx_q, dy_q, px, py;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cx_q <= '0;
      cy_q <= '0;
      dx_q <= DX_MIN;
      dy_q <= DY_MIN;
    end else if (load_i) begin
      cx_q <= {2'b00, ctr_x_i};
      cy_q <= {2'b00, ctr_y_i};
      dx_q <= DX_MIN;
      dy_q <= DY_MIN;
    end else if (step_i) begin
      if (dx_q == DX_MAX) begin
        dx_q <= DX_MIN;
        dy_q <= dy_q + 1'b1;
      end else begin
        dx_q <= dx_q + 1'b1;
      end
    end
  end

  assign px = cx_q + dx_q;
  assign py = cy_q + dy_q;
  assign x_o = px[COORD_W-1:0];
  assign y_o = py[COORD_W-1:0];
  // negative or >= 2^COORD_W is outside the image
  assign in_range_o = !px[SW-1] && !px[COORD_W] && !py[SW-1] && !py[COORD_W];
  assign last_o = (dx_q == DX_MAX) && (dy_q == DY_MAX);
endmodule

// File: rtl/stereo_seek_tol.sv
module stereo_seek_tol #(
  parameter int PIX_W = 8,
  parameter int TOL   = 8
) (
  input  logic [PIX_W-1:0] a_i,
  input  logic [PIX_W-1:0] b_i,
  output logic             hit_o
);
  logic [PIX_W-1:0] diff;
  assign diff  = (a_i >= b_i) ? (a_i - b_i) : (b_i - a_i);
  assign hit_o = {1'b0, diff} <= (PIX_W + 1)'(TOL);
endmodule

// File: rtl/stereo_seeker.sv
module stereo_seeker
  import stereo_seek_pkg::*;
#(
  parameter int COORD_W   = 7,
  parameter int PIX_W     = 8,
  parameter int HALF_H    = 3,
  parameter int HALF_V    = 2,
  parameter int TOL       = 8,
  parameter int THRESH    = 16,
  parameter int FRAME_CYC = 1000000,
  localparam int AW       = 2 * COORD_W,
  localparam int WIN_N    = (2 * HALF_H + 1) * (2 * HALF_V + 1),
  localparam int MAX_EL   = 2 * (1 << AW) + 2 + 2 * WIN_N,
  localparam int ELW      = $clog2(MAX_EL + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_i,
  output logic [AW-1:0]      m_addr_o,
  input  logic [PIX_W-1:0]   m_data_i,
  output logic [AW-1:0]      lut_addr_o,
  input  logic [COORD_W-1:0] lut_x_i,
  input  logic [COORD_W-1:0] lut_y_i,
  output logic [AW-1:0]      s_addr_o,
  input  logic [PIX_W-1:0]   s_data_i,
  output logic               done_o,
  output logic               match_o,
  output logic [COORD_W-1:0] match_x_o,
  output logic [COORD_W-1:0] match_y_o,
  output logic [ELW-1:0]     elapsed_o
);
  seek_state_e        state_q;
  logic               phase_q;
  logic [AW-1:0]      m_idx_q;
  logic [PIX_W-1:0]   m_val_q;
  logic [ELW-1:0]     cnt_q;
  logic               arm, hit, win_load, win_step, in_range, last;
  logic [COORD_W-1:0] wx, wy;

  stereo_seek_frame_timer #(.FRAME_CYC(FRAME_CYC)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .arm_o(arm)
  );

  stereo_seek_window #(.COORD_W(COORD_W), .HALF_H(HALF_H), .HALF_V(HALF_V)) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(win_load),
    .ctr_x_i(lut_x_i), .ctr_y_i(lut_y_i), .step_i(win_step),
    .x_o(wx), .y_o(wy), .in_range_o(in_range), .last_o(last)
  );

  stereo_seek_tol #(.PIX_W(PIX_W), .TOL(TOL)) u_tol (
    .a_i(s_data_i), .b_i(m_val_q), .hit_o(hit)
  );

  assign m_addr_o   = m_idx_q;
  assign lut_addr_o = m_idx_q;
  assign s_addr_o   = {wy, wx};

  assign win_load = (state_q == ST_LUT) && phase_q;
  assign win_step = (state_q == ST_WIN) && !frame_i && !last &&
                    (!in_range || (phase_q && !hit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      phase_q   <= 1'b0;
      m_idx_q   <= '0;
      m_val_q   <= '0;
      cnt_q     <= '0;
      done_o    <= 1'b0;
      match_o   <= 1'b0;
      match_x_o <= '0;
      match_y_o <= '0;
      elapsed_o <= '0;
    end else if (frame_i) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      done_o  <= 1'b0;
      match_o <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      match_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (arm) begin
          state_q <= ST_MSCAN;
          m_idx_q <= '0;
          phase_q <= 1'b0;
          cnt_q   <= '0;
        end
        ST_MSCAN: begin
          cnt_q   <= cnt_q + 1'b1;
          phase_q <= !phase_q;
          if (phase_q) begin
            if (m_data_i >= PIX_W'(THRESH)) begin
              m_val_q <= m_data_i;
              state_q <= ST_LUT;
            end else if (m_idx_q == '1) begin
              state_q <= ST_HOLD;   // no active master pixel
            end else begin
              m_idx_q <= m_idx_q + 1'b1;
            end
          end
        end
        ST_LUT: begin
          cnt_q   <= cnt_q + 1'b1;
          phase_q <= !phase_q;
          if (phase_q) state_q <= ST_WIN;
        end
        ST_WIN: begin
          cnt_q <= cnt_q + 1'b1;
          if (in_range && !phase_q) begin
            phase_q <= 1'b1;
          end else begin
            phase_q <= 1'b0;
            if (in_range && hit) begin
              done_o    <= 1'b1;
              match_o   <= 1'b1;
              match_x_o <= wx;
              match_y_o <= wy;
              elapsed_o <= cnt_q + 1'b1;
              state_q   <= ST_HOLD;
            end else if (last) begin
              done_o    <= 1'b1;
              match_x_o <= '0;
              match_y_o <= '0;
              elapsed_o <= cnt_q + 1'b1;
              state_q   <= ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stereo_seeker_chk.sv
module stereo_seeker_chk #(
  parameter int COORD_W   = 7,
  parameter int HALF_H    = 3,
  parameter int HALF_V    = 2,
  parameter int FRAME_CYC = 1000000,
  parameter int ELW       = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           frame_i,
  input logic           done_o,
  input logic           match_o,
  input logic [ELW-1:0] elapsed_o
);
  localparam int HALF   = FRAME_CYC / 2;
  localparam int HW     = $clog2(HALF + 1);
  localparam int WIN_N  = (2 * HALF_H + 1) * (2 * HALF_V + 1);
  localparam int MAX_EL = 2 * (1 << (2 * COORD_W)) + 2 + 2 * WIN_N;

  logic [HW-1:0] since_q;
  logic          res_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q    <= '0;
      res_seen_q <= 1'b0;
    end else if (frame_i) begin
      since_q    <= '0;
      res_seen_q <= 1'b0;
    end else begin
      if (since_q != HW'(HALF)) since_q <= since_q + 1'b1;
      if (done_o) res_seen_q <= 1'b1;
    end
  end

  AST_START_AFTER_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> since_q == HW'(HALF)); // R2
  AST_ONE_PER_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !res_seen_q); // R2
  AST_BOUNDED_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> elapsed_o <= ELW'(MAX_EL)); // R9
  AST_ABORT_NO_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> !done_o); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_MATCH_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> done_o); // R11
endmodule

bind stereo_seeker stereo_seeker_chk #(
  .COORD_W(COORD_W), .HALF_H(HALF_H), .HALF_V(HALF_V),
  .FRAME_CYC(FRAME_CYC), .ELW(ELW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i),
  .done_o(done_o), .match_o(match_o), .elapsed_o(elapsed_o)
);

// File: tb/stereo_seeker_tb.sv
module stereo_seeker_tb;
  localparam int CW = 4;
  localparam int W = 16;
  localparam int N = 256;
  localparam int HH = 3;
  localparam int HV = 2;
  localparam int TOL = 8;
  localparam int THRESH = 16;
  localparam int FRAME = 200;
  localparam int HALF = FRAME / 2;
  localparam int ELW = $clog2(2 * N + 2 + 2 * 35 + 1);

  logic clk = 0;
  logic rst_n = 0;
  logic frame = 0;
  logic [7:0] m_addr, lut_addr, s_addr;
  logic [7:0] m_q, s_q;
  logic [3:0] lx_q, ly_q, mx, my;
  logic done, match;
  logic [ELW-1:0] elapsed;

  logic [7:0] mmem [0:N-1];
  logic [7:0] smem [0:N-1];
  logic [3:0] lxm [0:N-1];
  logic [3:0] lym [0:N-1];

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    m_q  <= mmem[m_addr];
    lx_q <= lxm[lut_addr];
    ly_q <= lym[lut_addr];
    s_q  <= smem[s_addr];
  end

  stereo_seeker #(.COORD_W(CW), .PIX_W(8), .HALF_H(HH), .HALF_V(HV),
                  .TOL(TOL), .THRESH(THRESH), .FRAME_CYC(FRAME)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame),
    .m_addr_o(m_addr), .m_data_i(m_q),
    .lut_addr_o(lut_addr), .lut_x_i(lx_q), .lut_y_i(ly_q),
    .s_addr_o(s_addr), .s_data_i(s_q),
    .done_o(done), .match_o(match), .match_x_o(mx), .match_y_o(my),
    .elapsed_o(elapsed)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_maps();
    for (int i = 0; i < N; i++) begin
      mmem[i] = 0; smem[i] = 0; lxm[i] = 0; lym[i] = 0;
    end
  endtask

  // reference: first active master, row-major window, skip costs 1, read costs 2
  task automatic model(output bit has, output int b, output int ex, output int ey,
                       output bit em);
    int k, cx, cy, mv, d;
    k = -1; has = 0; b = 0; ex = 0; ey = 0; em = 0;
    for (int i = 0; i < N; i++)
      if (k < 0 && mmem[i] >= THRESH) k = i;
    if (k < 0) return;
    has = 1;
    mv = mmem[k]; cx = lxm[k]; cy = lym[k];
    b = 2 * (k + 1) + 2;
    for (int dy = -HV; dy <= HV; dy++)
      for (int dx = -HH; dx <= HH; dx++) begin
        if (!em) begin
          if (cx + dx < 0 || cx + dx >= W || cy + dy < 0 || cy + dy >= W) b += 1;
          else begin
            b += 2;
            d = int'(smem[(cy + dy) * W + cx + dx]) - mv;
            if (d < 0) d = -d;
            if (d <= TOL) begin em = 1; ex = cx + dx; ey = cy + dy; end
          end
        end
      end
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame = 1;
    @(negedge clk); frame = 0;
  endtask

  task automatic wait_result(input int limit, output bit seen, output int n,
                             output int rx, output int ry, output int rel,
                             output bit rm);
    seen = 0; n = 0; rx = 0; ry = 0; rel = 0; rm = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (!seen && done) begin
        seen = 1; n = i; rx = mx; ry = my; rel = int'(elapsed); rm = match;
        break;
      end
    end
  endtask

  task automatic run_search(input string req);
    bit has, em, seen, rm;
    int b, ex, ey, n, rx, ry, rel;
    model(has, b, ex, ey, em);
    pulse_frame();
    if (!has) begin
      wait_result(HALF + 2 * N + 100, seen, n, rx, ry, rel, rm);
      chk("R3", "no result without active master", int'(seen), 0);
      return;
    end
    wait_result(HALF + b + 20, seen, n, rx, ry, rel, rm);
    chk(req, "result issued", int'(seen), 1);
    chk("R2", "cycles strobe to result", n, HALF + b);
    chk(req, "match flag", int'(rm), int'(em));
    chk(req, "match x", rx, ex);
    chk(req, "match y", ry, ey);
    chk("R9", "elapsed", rel, b);
    @(negedge clk);
    chk("R11", "done single pulse", int'(done), 0);
    chk("R11", "match follows done", int'(match), 0);
  endtask

  task automatic setup_basic();
    clear_maps();
    mmem[20] = 100; lxm[20] = 8; lym[20] = 8;
    smem[7 * W + 7] = 200;
    smem[8 * W + 9] = 106;
    smem[9 * W + 5] = 100;
  endtask

  task automatic t_basic();  // R4 R5
    setup_basic();
    run_search("R5");
    chk("R4", "centre from table", int'(mx), 9);
  endtask

  task automatic t_threshold();  // R3
    clear_maps();
    mmem[3] = 15; lxm[3] = 2; lym[3] = 2; smem[2 * W + 2] = 15;
    mmem[40] = 16; lxm[40] = 12; lym[40] = 12; smem[12 * W + 12] = 16;
    run_search("R3");
    chk("R3", "selected master window x", int'(mx), 12);
  endtask

  task automatic t_tolerance();  // R6
    clear_maps();
    mmem[5] = 50; lxm[5] = 6; lym[5] = 6;
    smem[4 * W + 6] = 59;
    smem[5 * W + 3] = 42;
    run_search("R6");
    chk("R6", "edge accept x", int'(mx), 3);
    chk("R6", "edge accept y", int'(my), 5);
  endtask

  task automatic t_corner_low();  // R7
    clear_maps();
    mmem[0] = 200; lxm[0] = 0; lym[0] = 0;
    smem[1 * W + 2] = 195;
    run_search("R7");
  endtask

  task automatic t_corner_empty();  // R7 R8
    clear_maps();
    mmem[7] = 90; lxm[7] = 15; lym[7] = 15;
    run_search("R8");
  endtask

  task automatic t_out_tol();  // R8
    clear_maps();
    mmem[100] = 80; lxm[100] = 7; lym[100] = 7;
    for (int y = 5; y <= 9; y++)
      for (int x = 4; x <= 10; x++) smem[y * W + x] = 200;
    run_search("R8");
  endtask

  task automatic t_no_master();  // R3
    clear_maps();
    mmem[9] = 15;
    run_search("R3");
  endtask

  task automatic t_abort_mid();  // R10
    bit has, em, seen, rm;
    int b, ex, ey, n, rx, ry, rel, early;
    setup_basic();
    model(has, b, ex, ey, em);
    pulse_frame();
    early = 0;
    for (int i = 0; i < HALF + 5; i++) begin
      @(negedge clk);
      if (done) early++;
    end
    pulse_frame();
    if (done) early++;
    chk("R10", "no result from aborted search", early, 0);
    wait_result(HALF + b + 20, seen, n, rx, ry, rel, rm);
    chk("R10", "restarted search timing", n, HALF + b);
  endtask

  task automatic t_abort_same();  // R10
    bit has, em, seen, rm;
    int b, ex, ey, n, rx, ry, rel, early;
    setup_basic();
    model(has, b, ex, ey, em);
    pulse_frame();
    early = 0;
    for (int i = 0; i < HALF + b - 2; i++) begin
      @(negedge clk);
      if (done) early++;
    end
    pulse_frame();  // strobe sampled on the would-be result edge
    if (done) early++;
    chk("R10", "strobe on result edge suppresses", early, 0);
    wait_result(HALF + b + 20, seen, n, rx, ry, rel, rm);
    chk("R10", "search after coincident strobe", n, HALF + b);
    chk("R10", "match x after restart", rx, ex);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog R2: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_maps();
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", int'(done), 0);
    chk("R1", "match in reset", int'(match), 0);
    chk("R1", "master addr in reset", int'(m_addr), 0);
    rst_n = 1;
    t_basic();
    t_threshold();
    t_tolerance();
    t_corner_low();
    t_corner_empty();
    t_out_tol();
    t_no_master();
    t_abort_mid();
    t_abort_same();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule